// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a descriptor-driven DMA engine for an Ethernet MAC. A receive front end hands it finished frames as a byte stream. The last byte of each frame carries six error and classification flags. The engine walks a ring of 16-byte descriptors that starts at a programmable base address. It uses only descriptors that software has handed to the DMA. It packs the frame bytes little-endian into 32-bit words and writes them into the buffer that each descriptor names. It then writes a status word back over descriptor word 0, which clears the ownership bit and returns the entry to software.

A frame longer than one buffer continues in the following descriptors. When the engine meets a descriptor that software still owns, it stalls the byte stream and raises one no-buffer pulse. It then re-reads that descriptor at a programmed poll interval until software returns it. Frame completion and front-end frame drops are reported as single-cycle interrupt status pulses. Memory is reached through a single request/acknowledge word port.

Descriptor layout, at byte offsets from the descriptor start:
- Offset 0 (word 0) is the ownership and status word.
- Offset 4 (word 1) holds the end-of-ring flag and the buffer size.
- Offset 8 (word 2) holds the buffer byte address, which must be word aligned.
- Offset 12 (word 3) is left to software.

Every buffer size must be at least 1.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: After reset the block requests no memory access, holds inReady low and drives all three interrupt outputs low.
- R2: Before taking a frame, the block reads word 0 of the current descriptor. Only when bit 31 of word 0 is 1 (owned by the DMA) does it read word 1 and word 2 and accept bytes. Buffer byte k is stored in bits [8*(k%4)+7 : 8*(k%4)] of the word at buffer address + 4*(k/4).
- R3: The status written to word 0 has these fields: bit 31 = 0, bit 30 = first segment, bit 29 = last segment, bits 10:0 = the number of bytes stored in this buffer, and bits 21:16 = inFlags sampled with the last byte. The inFlags bits map as receive error [0], CRC error [1], frame too long [2], runt [3], odd nibble [4] and multicast [5]. The flag bits are zero on segments that are not the last. All other bits are zero.
- R4: The status write to word 0 is the final memory write for that descriptor. irqFrameDone pulses for one cycle right after the last segment's status write is acknowledged.
- R5: After a descriptor is written back, the next descriptor is at the current address + 16. When bit 31 of word 1 was set, the next descriptor is instead at ringBase.
- R6: A frame with more bytes than the buffer size in word 1 bits 10:0 continues in the next descriptor. Only the first descriptor carries the first marker and only the final one carries the last marker. The byte count never exceeds the buffer size.
- R7: When a fetched word 0 has bit 31 clear, no bytes are accepted and irqNoBuf pulses once for that wait. Word 0 is re-read with at least pollInterval+1 cycles between reads until the bit is set, and the frame then completes normally.
- R8: A one-cycle pulse on inDrop produces exactly one one-cycle pulse on irqLost in the following cycle.
- R9: While runEn is low, no new frame is started and no memory request is made. The current descriptor address is reloaded from ringBase, so the next frame uses the descriptor at the new base.
- R10: Once memReq is raised, it stays high with memAddr, memWe and memWdata unchanged until the cycle in which memAck is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Enables new frames; when low, the ring pointer follows ringBase |
| ringBase | input | ADDR_W | Byte address of the first descriptor |
| pollInterval | input | POLL_W | Idle cycles between re-reads of a software-owned descriptor |
| inValid | input | 1 | Frame byte valid |
| inData | input | 8 | Frame byte |
| inLast | input | 1 | Marks the last byte of a frame |
| inFlags | input | 6 | Frame flags, valid with inLast |
| inDrop | input | 1 | Front end dropped a frame |
| inReady | output | 1 | Byte is accepted when inValid and inReady are both high |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | One-cycle acknowledge; read data valid with it |
| memRdata | input | 32 | Read data |
| irqFrameDone | output | 1 | Frame written back (pulse) |
| irqNoBuf | output | 1 | Current descriptor owned by software (pulse) |
| irqLost | output | 1 | Front-end frame drop reported (pulse) |

## Verification
The bench aims at the segment boundaries:
- A frame that fills one buffer exactly at a word edge and ends exactly at the end of a 6-byte buffer. Here a wrong flush would lose the tail bytes or mark the last segment too early.
- A ring wrap through the end-of-ring flag, with an owned sentinel descriptor placed past the end. An engine that ignores the flag would write into the sentinel.
- A software-owned descriptor met by a waiting frame. A faulty engine would accept bytes into a buffer it does not own, pulse no-buffer on every poll, or poll without the programmed spacing.
- A change of ringBase while the engine is disabled. A stale pointer would send the next frame to the old ring.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // descriptor format, fixed by software
  localparam int DESC_BYTES = 16;
  localparam int OWN_BIT    = 31;
  localparam int FIRST_BIT  = 30;
  localparam int LAST_BIT   = 29;
  localparam int FLAG_LSB   = 16;
  localparam int NUM_FLAGS  = 6;
  localparam int LEN_W      = 11;
  localparam int EOR_BIT    = 31;

  typedef enum logic [1:0] {ADDR_W0, ADDR_W1, ADDR_W2, ADDR_BUF} addr_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH0, ST_WAIT, ST_FETCH1, ST_FETCH2, ST_RECV, ST_WRDATA, ST_WRSTAT
  } rx_state_e;

  typedef struct packed {
    logic      trackBase;
    logic      capSize;
    logic      capPtr;
    logic      take;
    logic      flushDone;
    logic      statDone;
    logic      pollLoad;
    logic      pollDec;
    logic      wrStatus;
    addr_sel_e addrSel;
  } rxr_strobe_t;
endpackage

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        inValid,
  input  logic        inDrop,
  input  logic        memAck,
  input  logic        rdOwned,
  input  logic        flushNeeded,
  input  logic        frameEnded,
  input  logic        segFull,
  input  logic        pollZero,
  output rxr_strobe_t strb,
  output logic        inReady,
  output logic        memReq,
  output logic        memWe,
  output logic        irqFrameDone,
  output logic        irqNoBuf,
  output logic        irqLost
);
  rx_state_e state, nextState;
  logic      noBufSeen;

  always_comb begin
    strb      = '0;
    nextState = state;
    inReady   = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (!runEn)       strb.trackBase = 1'b1;
        else if (inValid) nextState = ST_FETCH0;
      end
      ST_FETCH0: begin
        memReq       = 1'b1;
        strb.addrSel = ADDR_W0;
        if (memAck) begin
          if (rdOwned) nextState = ST_FETCH1;
          else begin
            nextState     = ST_WAIT;
            strb.pollLoad = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (pollZero) nextState = ST_FETCH0;
        else          strb.pollDec = 1'b1;
      end
      ST_FETCH1: begin
        memReq       = 1'b1;
        strb.addrSel = ADDR_W1;
        if (memAck) begin
          strb.capSize = 1'b1;
          nextState    = ST_FETCH2;
        end
      end
      ST_FETCH2: begin
        memReq       = 1'b1;
        strb.addrSel = ADDR_W2;
        if (memAck) begin
          strb.capPtr = 1'b1;
          nextState   = ST_RECV;
        end
      end
      ST_RECV: begin
        inReady   = !flushNeeded;
        strb.take = inReady && inValid;
        if (flushNeeded) nextState = ST_WRDATA;
      end
      ST_WRDATA: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.addrSel = ADDR_BUF;
        if (memAck) begin
          strb.flushDone = 1'b1;
          nextState      = (frameEnded || segFull) ? ST_WRSTAT : ST_RECV;
        end
      end
      ST_WRSTAT: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strb.addrSel  = ADDR_W0;
        strb.wrStatus = 1'b1;
        if (memAck) begin
          strb.statDone = 1'b1;
          nextState     = frameEnded ? ST_IDLE : ST_FETCH0;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      noBufSeen    <= 1'b0;
      irqFrameDone <= 1'b0;
      irqNoBuf     <= 1'b0;
      irqLost      <= 1'b0;
    end else begin
      state        <= nextState;
      irqLost      <= inDrop;
      irqFrameDone <= (state == ST_WRSTAT) && memAck && frameEnded;
      irqNoBuf     <= (state == ST_FETCH0) && memAck && !rdOwned && !noBufSeen;
      if (state == ST_FETCH0 && memAck) noBufSeen <= !rdOwned;
    end
  end

  // R10: a request stays up, with its direction, until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe));
  // R4: completion only follows an acknowledged write
  p_done_after_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqFrameDone |-> $past(memAck && memWe));
  // R7: no-buffer status is a single-cycle pulse
  p_nobuf_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqNoBuf |=> !irqNoBuf);
endmodule

// File: rtl/rxr_datapath.sv
module rxr_datapath
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int POLL_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxr_strobe_t          strb,
  input  logic [ADDR_W-1:0]    ringBase,
  input  logic [POLL_W-1:0]    pollInterval,
  input  logic [7:0]           inData,
  input  logic                 inLast,
  input  logic [NUM_FLAGS-1:0] inFlags,
  input  logic [31:0]          memRdata,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [31:0]          memWdata,
  output logic                 flushNeeded,
  output logic                 frameEnded,
  output logic                 segFull,
  output logic                 pollZero
);
  localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(DESC_BYTES);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  logic [ADDR_W-1:0]    descAddr, bufPtr;
  logic                 endOfRing, firstSeg;
  logic [LEN_W-1:0]     bufSize, segBytes;
  logic [31:0]          wordReg, statusWord;
  logic [2:0]           laneCnt;
  logic [NUM_FLAGS-1:0] flagReg;
  logic [POLL_W-1:0]    pollCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr   <= ringBase;
      bufPtr     <= '0;
      endOfRing  <= 1'b0;
      firstSeg   <= 1'b1;
      bufSize    <= '0;
      segBytes   <= '0;
      wordReg    <= '0;
      laneCnt    <= '0;
      flagReg    <= '0;
      frameEnded <= 1'b0;
      pollCnt    <= '0;
    end else begin
      if (strb.trackBase) descAddr <= ringBase;
      if (strb.capSize) begin
        endOfRing <= memRdata[EOR_BIT];
        bufSize   <= memRdata[LEN_W-1:0];
      end
      if (strb.capPtr) bufPtr <= memRdata[ADDR_W-1:0];
      if (strb.take) begin
        wordReg[8*laneCnt[1:0] +: 8] <= inData;
        laneCnt  <= laneCnt + 3'd1;
        segBytes <= segBytes + LEN_W'(1);
        if (inLast) begin
          frameEnded <= 1'b1;
          flagReg    <= inFlags;
        end
      end
      if (strb.flushDone) begin
        bufPtr  <= bufPtr + WORD_STEP;
        laneCnt <= '0;
        wordReg <= '0;
      end
      if (strb.statDone) begin
        descAddr   <= endOfRing ? ringBase : descAddr + DESC_STEP;
        segBytes   <= '0;
        firstSeg   <= frameEnded;
        frameEnded <= 1'b0;
        flagReg    <= '0;
      end
      if (strb.pollLoad)     pollCnt <= pollInterval;
      else if (strb.pollDec) pollCnt <= pollCnt - POLL_W'(1);
    end
  end

  assign segFull     = (segBytes == bufSize);
  assign flushNeeded = (laneCnt == 3'd4) || frameEnded || segFull;
  assign pollZero    = (pollCnt == '0);

  always_comb begin
    statusWord                          = '0;
    statusWord[FIRST_BIT]               = firstSeg;
    statusWord[LAST_BIT]                = frameEnded;
    statusWord[FLAG_LSB +: NUM_FLAGS]   = flagReg;
    statusWord[LEN_W-1:0]               = segBytes;
  end

  always_comb begin
    case (strb.addrSel)
      ADDR_W0:  memAddr = descAddr;
      ADDR_W1:  memAddr = descAddr + WORD_STEP;
      ADDR_W2:  memAddr = descAddr + (WORD_STEP << 1);
      default:  memAddr = bufPtr;
    endcase
  end

  assign memWdata = strb.wrStatus ? statusWord : wordReg;

  // R6: a buffer never holds more bytes than its size
  p_seg_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    segBytes <= bufSize);
  // R5: end-of-ring sends the next fetch back to the base
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.statDone && endOfRing |=> descAddr == $past(ringBase));
endmodule

// File: rtl/rx_desc_ring_writer.sv
module rx_desc_ring_writer
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int POLL_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 runEn,
  input  logic [ADDR_W-1:0]    ringBase,
  input  logic [POLL_W-1:0]    pollInterval,
  input  logic                 inValid,
  input  logic [7:0]           inData,
  input  logic                 inLast,
  input  logic [NUM_FLAGS-1:0] inFlags,
  input  logic                 inDrop,
  output logic                 inReady,
  output logic                 memReq,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [31:0]          memWdata,
  input  logic                 memAck,
  input  logic [31:0]          memRdata,
  output logic                 irqFrameDone,
  output logic                 irqNoBuf,
  output logic                 irqLost
);
  rxr_strobe_t strb;
  logic flushNeeded, frameEnded, segFull, pollZero;

  rxr_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .runEn        (runEn),
    .inValid      (inValid),
    .inDrop       (inDrop),
    .memAck       (memAck),
    .rdOwned      (memRdata[OWN_BIT]),
    .flushNeeded  (flushNeeded),
    .frameEnded   (frameEnded),
    .segFull      (segFull),
    .pollZero     (pollZero),
    .strb         (strb),
    .inReady      (inReady),
    .memReq       (memReq),
    .memWe        (memWe),
    .irqFrameDone (irqFrameDone),
    .irqNoBuf     (irqNoBuf),
    .irqLost      (irqLost)
  );

  rxr_datapath #(.ADDR_W(ADDR_W), .POLL_W(POLL_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .ringBase     (ringBase),
    .pollInterval (pollInterval),
    .inData       (inData),
    .inLast       (inLast),
    .inFlags      (inFlags),
    .memRdata     (memRdata),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .flushNeeded  (flushNeeded),
    .frameEnded   (frameEnded),
    .segFull      (segFull),
    .pollZero     (pollZero)
  );

  // R10: address and write data are held while a request waits
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWdata));
endmodule

// File: tb/tb_rx_desc_ring_writer.sv
module tb_rx_desc_ring_writer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b1;
  logic [31:0] ringBase = 32'h100;
  logic [7:0]  pollInterval = 8'd3;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inLast = 1'b0;
  logic [5:0]  inFlags = '0;
  logic        inDrop = 1'b0;
  logic        inReady, memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        irqFrameDone, irqNoBuf, irqLost;

  always #4 clk = ~clk;

  rx_desc_ring_writer dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .ringBase(ringBase),
    .pollInterval(pollInterval), .inValid(inValid), .inData(inData),
    .inLast(inLast), .inFlags(inFlags), .inDrop(inDrop), .inReady(inReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .irqFrameDone(irqFrameDone),
    .irqNoBuf(irqNoBuf), .irqLost(irqLost)
  );

  int tests = 0, fails = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] lastWrAddr = '0, watchAddr = 32'hFFFF_FFFF;
  int cyc = 0, wrCount = 0, watchReads = 0, lastRd = 0, minGap = 1000;
  int doneCnt = 0, noBufCnt = 0, lostCnt = 0, readyCnt = 0, reqCnt = 0, protoErr = 0;
  logic        pendPrev = 1'b0;
  logic [31:0] addrPrev = '0;

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) memAck <= 1'b0;
    else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        memAck <= 1'b1;
        if (memWe) begin
          mem[memAddr[11:2]] <= memWdata;
          lastWrAddr <= memAddr;
          wrCount <= wrCount + 1;
        end else begin
          memRdata <= mem[memAddr[11:2]];
          if (memAddr == watchAddr) begin
            if (watchReads > 0 && (cyc - lastRd) < minGap) minGap <= cyc - lastRd;
            lastRd <= cyc;
            watchReads <= watchReads + 1;
          end
        end
      end
    end
  end

  // output monitors, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (irqFrameDone) doneCnt <= doneCnt + 1;
      if (irqNoBuf) noBufCnt <= noBufCnt + 1;
      if (irqLost) lostCnt <= lostCnt + 1;
      if (inReady) readyCnt <= readyCnt + 1;
      if (memReq) reqCnt <= reqCnt + 1;
      if (pendPrev && (!memReq || memAddr != addrPrev)) protoErr <= protoErr + 1;
      pendPrev <= memReq && !memAck;
      addrPrev <= memAddr;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic setDesc(input logic [31:0] a, input bit own, input bit eor,
                         input int size, input logic [31:0] bufAddr);
    mem[a[11:2]]     = {own, 31'b0};
    mem[a[11:2] + 1] = {eor, 20'b0, 11'(size)};
    mem[a[11:2] + 2] = bufAddr;
    mem[a[11:2] + 3] = '0;
  endtask

  task automatic sendFrame(input int len, input logic [7:0] seed, input logic [5:0] flags);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1;
      inData  = seed + 8'(i);
      inLast  = (i == len - 1);
      inFlags = (i == len - 1) ? flags : 6'b0;
      @(negedge clk);
      while (!inReady) @(negedge clk);
      @(posedge clk);
      #1;
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    inFlags = '0;
  endtask

  task automatic waitDone(input int target, input string tag);
    int n = 0;
    while (doneCnt < target && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    check(doneCnt == target, tag, "frame-done pulse count", doneCnt, target);
  endtask

  function automatic logic [7:0] rdByte(input logic [31:0] a);
    logic [31:0] w = mem[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic checkBuf(input logic [31:0] bufAddr, input int len,
                          input logic [7:0] seed, input string tag);
    int bad = -1;
    for (int k = 0; k < len; k++)
      if (bad < 0 && rdByte(bufAddr + k) != seed + 8'(k)) bad = k;
    check(bad < 0, tag, "buffer bytes", (bad < 0) ? 0 : rdByte(bufAddr + bad),
          (bad < 0) ? 0 : seed + 8'(bad));
  endtask

  // single frame into an owned descriptor
  task automatic testSimple;
    sendFrame(10, 8'h10, 6'b0);
    waitDone(1, "R2");
    checkBuf(32'h400, 10, 8'h10, "R2");
    check(mem[32'h100 >> 2] == 32'h6000_000A, "R3", "single status word", mem[32'h100 >> 2], 32'h6000_000A);
    check(lastWrAddr == 32'h100, "R4", "status is last write", lastWrAddr, 32'h100);
  endtask

  // flags land in status bits 21:16
  task automatic testFlags;
    sendFrame(7, 8'h30, 6'b100010);
    waitDone(2, "R3");
    checkBuf(32'h440, 7, 8'h30, "R3");
    check(mem[32'h110 >> 2] == 32'h6022_0007, "R3", "flag status word", mem[32'h110 >> 2], 32'h6022_0007);
  endtask

  // 20 bytes over buffers of 8, 6 and 6
  task automatic testSplit;
    sendFrame(20, 8'h50, 6'b000101);
    waitDone(3, "R6");
    checkBuf(32'h480, 8, 8'h50, "R6");
    checkBuf(32'h4C0, 6, 8'h58, "R6");
    checkBuf(32'h500, 6, 8'h5E, "R6");
    check(mem[32'h120 >> 2] == 32'h4000_0008, "R6", "first segment word", mem[32'h120 >> 2], 32'h4000_0008);
    check(mem[32'h130 >> 2] == 32'h0000_0006, "R6", "middle segment word", mem[32'h130 >> 2], 32'h0000_0006);
    check(mem[32'h140 >> 2] == 32'h2005_0006, "R6", "last segment word", mem[32'h140 >> 2], 32'h2005_0006);
    check(lastWrAddr == 32'h140, "R4", "last write of split frame", lastWrAddr, 32'h140);
  endtask

  // end-of-ring entry, then wrap to the base
  task automatic testWrap;
    sendFrame(5, 8'h70, 6'b0);
    waitDone(4, "R5");
    check(mem[32'h150 >> 2] == 32'h6000_0005, "R5", "ring end status", mem[32'h150 >> 2], 32'h6000_0005);
    setDesc(32'h100, 1'b1, 1'b0, 64, 32'h400);
    sendFrame(12, 8'h90, 6'b0);
    waitDone(5, "R5");
    checkBuf(32'h400, 12, 8'h90, "R5");
    check(mem[32'h100 >> 2] == 32'h6000_000C, "R5", "wrapped status", mem[32'h100 >> 2], 32'h6000_000C);
    check(mem[32'h160 >> 2] == 32'h8000_0000, "R5", "sentinel past ring end", mem[32'h160 >> 2], 32'h8000_0000);
  endtask

  // next entry still owned by software
  task automatic testNoBuf;
    int nb0 = noBufCnt, rd0 = readyCnt, wr0 = wrCount;
    watchAddr = 32'h110;
    fork
      sendFrame(9, 8'hB0, 6'b0);
      begin
        repeat (60) @(negedge clk);
        check(noBufCnt - nb0 == 1, "R7", "no-buffer pulses", noBufCnt - nb0, 1);
        check(readyCnt == rd0, "R7", "inReady while blocked", readyCnt - rd0, 0);
        check(wrCount == wr0, "R7", "writes while blocked", wrCount - wr0, 0);
        check(watchReads >= 2, "R7", "re-reads of word 0", watchReads, 2);
        check(minGap >= 4, "R7", "poll spacing", minGap, 4);
        setDesc(32'h110, 1'b1, 1'b0, 64, 32'h440);
      end
    join
    waitDone(6, "R7");
    checkBuf(32'h440, 9, 8'hB0, "R7");
    check(mem[32'h110 >> 2] == 32'h6000_0009, "R7", "status after return", mem[32'h110 >> 2], 32'h6000_0009);
  endtask

  task automatic testDrop;
    int l0 = lostCnt;
    @(negedge clk); inDrop = 1'b1;
    @(negedge clk); inDrop = 1'b0;
    #1;
    check(irqLost == 1'b1, "R8", "lost pulse next cycle", irqLost, 1);
    repeat (4) @(negedge clk);
    check(lostCnt - l0 == 1, "R8", "lost pulse count", lostCnt - l0, 1);
  endtask

  // disabled engine ignores a waiting frame, then follows a new base
  task automatic testRunEn;
    int q0;
    @(negedge clk);
    runEn = 1'b0;
    ringBase = 32'h200;
    setDesc(32'h200, 1'b1, 1'b1, 64, 32'h5C0);
    q0 = reqCnt;
    inValid = 1'b1; inData = 8'hEE;
    repeat (20) @(negedge clk);
    check(reqCnt == q0, "R9", "requests while disabled", reqCnt - q0, 0);
    check(inReady == 1'b0, "R9", "inReady while disabled", inReady, 0);
    inValid = 1'b0;
    runEn = 1'b1;
    sendFrame(6, 8'hD0, 6'b0);
    waitDone(7, "R9");
    checkBuf(32'h5C0, 6, 8'hD0, "R9");
    check(mem[32'h200 >> 2] == 32'h6000_0006, "R9", "new base status", mem[32'h200 >> 2], 32'h6000_0006);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    setDesc(32'h100, 1'b1, 1'b0, 64, 32'h400);
    setDesc(32'h110, 1'b1, 1'b0, 64, 32'h440);
    setDesc(32'h120, 1'b1, 1'b0, 8,  32'h480);
    setDesc(32'h130, 1'b1, 1'b0, 6,  32'h4C0);
    setDesc(32'h140, 1'b1, 1'b0, 6,  32'h500);
    setDesc(32'h150, 1'b1, 1'b1, 64, 32'h540);
    setDesc(32'h160, 1'b1, 1'b0, 64, 32'h580);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(memReq == 1'b0, "R1", "memReq after reset", memReq, 0);
    check(inReady == 1'b0, "R1", "inReady after reset", inReady, 0);
    check({irqFrameDone, irqNoBuf, irqLost} == 3'b0, "R1", "interrupts after reset",
          {irqFrameDone, irqNoBuf, irqLost}, 0);
    testSimple();
    testFlags();
    testSplit();
    testWrap();
    testNoBuf();
    testDrop();
    testRunEn();
    check(protoErr == 0, "R10", "request held until ack", protoErr, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule